// File: doc/BRIEF.md
# Polyphase Non-Recursive CIC Decimator

This block is the first decimation stage behind a sigma-delta modulator. It takes a stream of 4-bit two's-complement samples, each qualified by a valid strobe. For every 64 accepted samples it produces one full-precision result. The transfer function is a fourth-order comb-integrator response, the cube of a 64-tap boxcar convolved once more with itself, so (sum of z^-k for k = 0..63)^4. The block has no multipliers and stores no coefficients. Compensation filtering, later rate reduction and gain scaling belong to the stages that follow.

The response is factored into six identical sections in cascade. Each section applies the binomial kernel (1 + z^-1)^4 and keeps every second result. A section stores its last four inputs and toggles a phase bit. On every second accepted input it registers one output, so the arithmetic of stage k only matters at 1/2^k of the input rate. No integrator runs at the full rate, which means no state can wrap around. Each section widens the word by 4 bits, and the 28-bit result is exact.

The reset input is asynchronous and active low. Internally its release is synchronised to the clock over two flops.

Top module: `cic_poly_decim`

## Requirements
- R1: While reset is low, and directly after it is released, `out_valid` is 0 and `out_data` is 0. The first results after reset are computed as if every sample before the first accepted one were zero.
- R2: `in_data` is read as a 4-bit two's-complement value, and only in cycles where `in_valid` is 1. Data presented with `in_valid` at 0 has no effect on any result.
- R3: `out_data` is a 28-bit two's-complement value with no rounding or truncation. A constant input of -8 settles at -134217728, and a constant input of 7 settles at 117440512.
- R4: Number the accepted samples x[0], x[1], ... from reset, and number the outputs from 0. Output j equals the sum over k of h[k]*x[64j+63-k], where h[k] is the coefficient of z^-k in (sum of z^-m for m = 0..63)^4, and x of a negative index is 0.
- R5: `out_valid` is 1 in exactly one cycle per 64 accepted samples. After 63 samples no output has appeared, and output j belongs to sample 64j+63.
- R6: A clock edge accepts sample 64j+63. `out_valid` for output j is then 1 in the cycle that follows the fifth clock edge after that edge.
- R7: `out_valid` never stays high for two consecutive cycles. Between pulses, `out_data` holds the last result.
- R8: Asserting reset in the middle of a stream discards all stored history and phase. The results that follow depend only on samples accepted after the reset.
- R9: A constant input c gives c*16777216 from output 3 onward, once the 253-tap response is filled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Qualifies `in_data` for the current cycle |
| in_data | input | 4 | Signed modulator sample |
| out_valid | output | 1 | One-cycle strobe for each decimated result |
| out_data | output | 28 | Signed full-precision decimated result |

## Verification
The hardest condition to reach from the ports is a decimation boundary that falls while the input strobe is irregular and the data lines carry junk between valid cycles. Only there does a wrong phase bit, or a history register that shifts on an idle cycle, produce a wrong value. The stimulus interleaves valid cycles with idle ones in an uneven pattern and drives changing junk data on the idle cycles. Every result is compared with a direct 253-tap convolution of the accepted samples, which the bench computes itself. A reset in the middle of a stream, and a stop at 63 samples, probe the phase boundary from both sides.

// File: rtl/cic_pkg.sv
package cic_pkg;

  // Number of nodes in a Pascal adder triangle of the given order.
  function automatic int tri_nodes(input int order);
    return ((order + 1) * (order + 2)) / 2;
  endfunction

  // Flat index of node i on level lvl of the triangle (level 0 has order+1 nodes).
  function automatic int tri_idx(input int order, input int lvl, input int i);
    return lvl * (order + 1) - (lvl * (lvl - 1)) / 2 + i;
  endfunction

endpackage

// File: rtl/cic_rst_sync.sv
module cic_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [DEPTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[DEPTH-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[DEPTH-1];

endmodule

// File: rtl/cic_half_stage.sv
module cic_half_stage
  import cic_pkg::*;
#(
  parameter int IW = 4,
  parameter int N  = 4,
  localparam int OW    = IW + N,
  localparam int NODES = tri_nodes(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);

  logic signed [IW-1:0] hist_q [1:N];
  logic signed [IW-1:0] hist_d [1:N];
  logic                 phase_q, phase_d;
  logic                 ov_q, ov_d;
  logic signed [OW-1:0] od_q, od_d;

  // Pascal triangle of pairwise adders: the apex equals sum C(N,k)*w[k].
  logic signed [OW-1:0] node [0:NODES-1];

  generate
    for (genvar i = 0; i <= N; i++) begin : g_leaf
      if (i == 0) begin : g_cur
        assign node[tri_idx(N, 0, 0)] = OW'(in_data);
      end else begin : g_old
        assign node[tri_idx(N, 0, i)] = OW'(hist_q[i]);
      end
    end
    for (genvar l = 1; l <= N; l++) begin : g_lvl
      for (genvar i = 0; i <= N - l; i++) begin : g_add
        assign node[tri_idx(N, l, i)] =
          node[tri_idx(N, l - 1, i)] + node[tri_idx(N, l - 1, i + 1)];
      end
    end
  endgenerate

  // Next-state logic
  always_comb begin
    hist_d  = hist_q;
    phase_d = phase_q;
    ov_d    = 1'b0;
    od_d    = od_q;
    if (in_valid) begin
      hist_d[1] = in_data;
      for (int k = 2; k <= N; k++) begin
        hist_d[k] = hist_q[k-1];
      end
      phase_d = ~phase_q;
      if (phase_q) begin
        ov_d = 1'b1;
        od_d = node[tri_idx(N, N, 0)];
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k <= N; k++) begin
        hist_q[k] <= '0;
      end
      phase_q <= 1'b0;
      ov_q    <= 1'b0;
      od_q    <= '0;
    end else begin
      ov_q <= ov_d;
      if (in_valid) begin
        hist_q  <= hist_d;
        phase_q <= phase_d;
        od_q    <= od_d;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R7

  AST_OUT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R5

  AST_HIST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(hist_q[1])); // R2

endmodule

// File: rtl/cic_poly_decim.sv
module cic_poly_decim #(
  parameter int IN_W  = 4,
  parameter int ORDER = 4,
  parameter int LOG2R = 6,
  parameter int SYNC  = 2,
  localparam int OUT_W = IN_W + ORDER * LOG2R
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  logic rst_n_i;

  cic_rst_sync #(.DEPTH(SYNC)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_i)
  );

  generate
    for (genvar s = 0; s < LOG2R; s++) begin : g_st
      localparam int SW = IN_W + ORDER * s;
      logic                         st_vin;
      logic signed [SW-1:0]         st_din;
      logic                         st_vld;
      logic signed [SW+ORDER-1:0]   st_dat;
      if (s == 0) begin : g_head
        assign st_vin = in_valid;
        assign st_din = in_data;
      end else begin : g_link
        assign st_vin = g_st[s-1].st_vld;
        assign st_din = g_st[s-1].st_dat;
      end
      cic_half_stage #(.IW(SW), .N(ORDER)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n_i),
        .in_valid  (st_vin),
        .in_data   (st_din),
        .out_valid (st_vld),
        .out_data  (st_dat)
      );
    end
  endgenerate

  assign out_valid = g_st[LOG2R-1].st_vld;
  assign out_data  = g_st[LOG2R-1].st_dat;

  // Rate bookkeeping for the checks below only.
  logic [31:0] chk_in_cnt, chk_out_cnt;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chk_in_cnt  <= '0;
      chk_out_cnt <= '0;
    end else begin
      if (in_valid)  chk_in_cnt  <= chk_in_cnt + 32'd1;
      if (out_valid) chk_out_cnt <= chk_out_cnt + 32'd1;
    end
  end

  AST_OUT_AFTER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n_i)
    out_valid |-> (chk_out_cnt < (chk_in_cnt >> LOG2R))); // R5

  AST_NO_BACKLOG: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((chk_in_cnt >> LOG2R) - chk_out_cnt) <= 32'd1); // R5

endmodule

// File: tb/cic_poly_decim_tb.sv
`timescale 1ns/1ps
module cic_poly_decim_tb;

  localparam int NTAP = 253;
  // Constant-input table: {input value, settled output}
  localparam int VEC [0:4][0:1] = '{
    '{ 7,  117440512},
    '{-8, -134217728},
    '{ 1,   16777216},
    '{-1,  -16777216},
    '{ 0,          0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_data = 4'd0;
  logic        out_valid;
  logic [27:0] out_data;

  always #2.5 clk = ~clk;

  cic_poly_decim u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 1'b0;

  int hcoef [0:NTAP-1];
  int xs    [0:4095];
  int acc_cyc [0:63];
  int cyc = 0;
  int in_count = 0;
  int out_idx = 0;
  int last_out = 0;
  bit have_out = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int j);
    int n, s;
    n = 64 * j + 63;
    s = 0;
    for (int k = 0; k < NTAP; k++) begin
      if (n - k >= 0 && n - k < 4096) s += hcoef[k] * xs[n-k];
    end
    return s;
  endfunction

  // Reference monitor: sampled on the falling edge, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      in_count = 0;
      out_idx  = 0;
      have_out = 1'b0;
    end else begin
      if (in_valid) begin
        if (in_count < 4096) xs[in_count] = int'($signed(in_data));
        if (in_count % 64 == 63 && in_count / 64 < 64) acc_cyc[in_count/64] = cyc;
        in_count++;
      end
      if (out_valid) begin
        chk(int'($signed(out_data)) == model(out_idx), "R4 value",
            int'($signed(out_data)), model(out_idx));
        if (out_idx < 64)
          chk(cyc - acc_cyc[out_idx] == 5, "R6 latency", cyc - acc_cyc[out_idx], 5);
        last_out = int'($signed(out_data));
        have_out = 1'b1;
        out_idx++;
      end else if (have_out) begin
        chk(int'($signed(out_data)) == last_out, "R7 hold",
            int'($signed(out_data)), last_out);
      end
    end
  end

  task automatic push(input bit v, input int d);
    @(negedge clk);
    #1;
    in_valid = v;
    in_data  = d[3:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) push(1'b0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1;
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    chk(out_data == '0, "R1 data in reset", int'($signed(out_data)), 0);
    #1;
    rst_n = 1'b1;
    idle(4);
    chk(out_valid == 1'b0, "R1 valid after release", int'(out_valid), 0);
  endtask

  function automatic int next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr[3:0]);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  endtask

  initial begin
    int tmp [0:NTAP-1];
    for (int k = 0; k < NTAP; k++) hcoef[k] = (k < 64) ? 1 : 0;
    for (int r = 0; r < 3; r++) begin
      for (int n = 0; n < NTAP; n++) begin
        tmp[n] = 0;
        for (int k = 0; k < 64; k++) if (n - k >= 0) tmp[n] += hcoef[n-k];
      end
      hcoef = tmp;
    end

    // R1: reset state
    do_reset();

    // R3, R9: constant-input table
    for (int v = 0; v < 5; v++) begin
      do_reset();
      for (int i = 0; i < 256; i++) push(1'b1, VEC[v][0]);
      idle(10);
      chk(last_out == VEC[v][1], "R9 R3 settled constant", last_out, VEC[v][1]);
      chk(out_idx == 4, "R5 output count", out_idx, 4);
    end

    // R4: impulse response
    do_reset();
    push(1'b1, 1);
    for (int i = 1; i < 512; i++) push(1'b1, 0);
    idle(10);
    chk(out_idx == 8, "R5 impulse output count", out_idx, 8);

    // R5: nothing after 63 samples, one output after the 64th
    do_reset();
    for (int i = 0; i < 63; i++) push(1'b1, 5);
    idle(12);
    chk(out_idx == 0, "R5 none after 63", out_idx, 0);
    push(1'b1, 5);
    idle(8);
    chk(out_idx == 1, "R5 one after 64", out_idx, 1);

    // R4, R6: pseudo-random dense stream
    do_reset();
    for (int i = 0; i < 1024; i++) push(1'b1, next_rand());
    idle(10);
    chk(out_idx == 16, "R5 dense output count", out_idx, 16);

    // R2: irregular strobe with junk data on idle cycles
    do_reset();
    begin
      int acc;
      acc = 0;
      while (acc < 640) begin
        int r;
        r = next_rand();
        if (r % 3 != 0) begin
          push(1'b1, next_rand());
          acc++;
        end else begin
          push(1'b0, next_rand() ^ 4'hA);
        end
      end
    end
    idle(10);
    chk(out_idx == 10, "R2 gapped output count", out_idx, 10);

    // R8: reset in mid-stream, then constant 3
    for (int i = 0; i < 100; i++) push(1'b1, -8);
    do_reset();
    chk(out_idx == 0, "R8 counters cleared", out_idx, 0);
    for (int i = 0; i < 256; i++) push(1'b1, 3);
    idle(10);
    chk(last_out == 3 * 16777216, "R8 fresh after reset", last_out, 3 * 16777216);
    chk(out_idx == 4, "R8 output count", out_idx, 4);

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

endmodule